// File: doc/BRIEF.md
# PHY Management Register Bank

This block is the management register bank of a gigabit copper transceiver. A host reaches it through a simple parallel port: a 5-bit register address, 16-bit write data with a write strobe, and a read strobe that returns 16-bit data one cycle later. Every address belongs to one of four classes: read/write, read-only, write-only, or not implemented. Only the first two return data, and only the first accepts writes. Each implemented entry comes out of reset with a fixed value. The extended identifier comes from a parameter.

The line side reports link state on a single level input. A change of that level updates the specific-status link fields and the negotiation-complete bit in the status register. The status register's link bit is latched low: a link drop clears it at once, but it only rises again on a status read that follows a return of the link. Writing the control register with its top bit set does not store the value. It starts a soft reset, which trims the control register, reloads status, masks specific status and sends a one-cycle link-reset pulse to the rest of the transceiver.

Top module: `mgmtRegBank`

## Requirements
- R1: After reset, reads return control 0x1140, status 0x7949, identifier 0x0141, extended identifier = parameter EXT_ID, advertisement 0x01E1, partner ability 0x01E0, gigabit control (address 9) 0x1E00, specific control (address 16) 0x0068 and specific status (address 17) 0x0000; rdData and linkResetPulse are 0.
- R2: rdData is loaded on the clock edge where rdEn is high and holds its value while rdEn is low.
- R3: Addresses 6, 7, 8, 15, 18–21, 26, 29 and 30 (not implemented or write-only) and every unused address (11–14, 22–25, 27, 28, 31) read as 0.
- R4: Only addresses 0, 4 and 16 store written data. Writes to any other address leave every readable value unchanged.
- R5: A write to address 0 with bit 15 set is a soft reset. Control becomes its old value AND 0x3140 (bits 6, 8, 12, 13 kept), status becomes 0x7949, and specific status is ANDed with 0xE001. Control bit 15 never reads as 1.
- R6: A soft reset raises linkResetPulse for exactly the one cycle after the write edge. No other write raises it.
- R7: Address 10 always reads 0x3C00.
- R8: A rising level on linkUp sets specific-status bits 15, 13, 11 and 10, clears bit 14, and sets status bit 5. It leaves status bit 2 unchanged.
- R9: A falling level on linkUp clears specific-status bits 15:13, 11 and 10, and clears status bits 2 and 5.
- R10: A read of status (address 1) returns the stored value. On the same edge, status bit 2 is loaded from specific-status bit 10, so the first read after a link drop shows bit 2 = 0.
- R11: When a linkUp change and a status read fall on the same edge, the read returns the value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Register address |
| wrData | input | 16 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 16 | Registered read data |
| linkUp | input | 1 | Line-side link level |
| linkResetPulse | output | 1 | One-cycle pulse after a soft reset |

## Verification
The assertions check, on every cycle, the rules that are local in time. Write strobes appear only for writable addresses. The gigabit status constant and the zero read-back of empty addresses appear one cycle after the strobe. Every link-reset pulse follows a control write with bit 15 set. A link drop clears the live and latched link bits on the next edge. Status bit 2 rises only after a status read that saw the live link bit set. Only the bench's scenarios can show the longer sequences: the latched-low bit hiding a return of the link until a second read, a down-then-up glitch that is still visible on the next read, the masks a soft reset applies to values written earlier, and a read that lands on the same edge as a link change.

// File: rtl/mgmtRegPkg.sv
package mgmtRegPkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [DATA_W-1:0] RST_CTRL    = 16'h1140;
  localparam logic [DATA_W-1:0] RST_STAT    = 16'h7949;
  localparam logic [DATA_W-1:0] VAL_ID      = 16'h0141;
  localparam logic [DATA_W-1:0] RST_ADV     = 16'h01E1;
  localparam logic [DATA_W-1:0] VAL_PARTNER = 16'h01E0;
  localparam logic [DATA_W-1:0] VAL_GCTRL   = 16'h1E00;
  localparam logic [DATA_W-1:0] VAL_GSTAT   = 16'h3C00;
  localparam logic [DATA_W-1:0] RST_SCTRL   = 16'h0068;
  localparam logic [DATA_W-1:0] CTRL_KEEP   = 16'h3140;
  localparam logic [DATA_W-1:0] SSTAT_KEEP  = 16'hE001;
  localparam logic [DATA_W-1:0] SSTAT_LINKM = 16'hEC00;
  localparam logic [DATA_W-1:0] SSTAT_UP    = 16'hAC00;
  localparam int SOFT_RST_BIT = 15;
  localparam int STAT_LINK_BIT = 2;
  localparam int STAT_ANDONE_BIT = 5;
  localparam int SSTAT_LIVE_BIT = 10;

  typedef enum logic [1:0] {ACC_RW, ACC_RO, ACC_WO, ACC_NONE} accClassE;

  typedef enum logic [3:0] {
    SRC_ZERO, SRC_CTRL, SRC_STAT, SRC_ID, SRC_EXTID, SRC_ADV,
    SRC_PARTNER, SRC_GCTRL, SRC_GSTAT, SRC_SCTRL, SRC_SSTAT
  } rdSrcE;

  typedef struct packed {
    logic  wrCtrl;
    logic  wrAdv;
    logic  wrSpecCtrl;
    logic  softRst;
    logic  rdStatus;
    logic  rdAny;
    rdSrcE rdSrc;
  } ctrlStbT;

  function automatic accClassE classify(input logic [ADDR_W-1:0] a);
    case (a)
      5'd0, 5'd4, 5'd16:                      classify = ACC_RW;
      5'd1, 5'd2, 5'd3, 5'd5, 5'd9, 5'd10,
      5'd17:                                  classify = ACC_RO;
      5'd29:                                  classify = ACC_WO;
      default:                                classify = ACC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/mgmtRegCtrl.sv
module mgmtRegCtrl
  import mgmtRegPkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrTop,
  input  logic              wrEn,
  input  logic              rdEn,
  output ctrlStbT           stb
);
  accClassE cls;

  always_comb begin
    cls = classify(addr);
    stb = '0;
    stb.rdSrc = SRC_ZERO;
    if (wrEn && cls == ACC_RW) begin
      unique case (addr)
        5'd0:    begin stb.softRst = wrTop; stb.wrCtrl = !wrTop; end
        5'd4:    stb.wrAdv = 1'b1;
        default: stb.wrSpecCtrl = 1'b1;
      endcase
    end
    if (rdEn) begin
      stb.rdAny = 1'b1;
      stb.rdStatus = (addr == 5'd1);
      if (cls == ACC_RW || cls == ACC_RO) begin
        case (addr)
          5'd0:    stb.rdSrc = SRC_CTRL;
          5'd1:    stb.rdSrc = SRC_STAT;
          5'd2:    stb.rdSrc = SRC_ID;
          5'd3:    stb.rdSrc = SRC_EXTID;
          5'd4:    stb.rdSrc = SRC_ADV;
          5'd5:    stb.rdSrc = SRC_PARTNER;
          5'd9:    stb.rdSrc = SRC_GCTRL;
          5'd10:   stb.rdSrc = SRC_GSTAT;
          5'd16:   stb.rdSrc = SRC_SCTRL;
          5'd17:   stb.rdSrc = SRC_SSTAT;
          default: stb.rdSrc = SRC_ZERO;
        endcase
      end
    end
  end

  // R4: at most one write action, and only for writable entries
  always_comb begin
    a_r4_one_write: assert ($onehot0({stb.wrCtrl, stb.wrAdv, stb.wrSpecCtrl, stb.softRst}));
    a_r4_rw_only: assert (!(stb.wrCtrl || stb.wrAdv || stb.wrSpecCtrl || stb.softRst) || classify(addr) == ACC_RW);
  end
endmodule

// File: rtl/mgmtRegData.sv
module mgmtRegData
  import mgmtRegPkg::*;
#(
  parameter logic [DATA_W-1:0] EXT_ID = 16'h0C54
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStbT           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              linkUp,
  output logic [DATA_W-1:0] rdData,
  output logic              linkResetPulse
);
  logic [DATA_W-1:0] ctrlQ, statQ, advQ, sctrlQ, sstatQ;
  logic [DATA_W-1:0] statN, sstatN, rdMux;
  logic linkSeenQ, upEvt, downEvt;

  assign upEvt   = linkUp && !linkSeenQ;
  assign downEvt = !linkUp && linkSeenQ;

  always_comb begin
    statN = statQ;
    if (stb.rdStatus) statN[STAT_LINK_BIT] = sstatQ[SSTAT_LIVE_BIT];
    if (stb.softRst) statN = RST_STAT;
    if (upEvt) statN[STAT_ANDONE_BIT] = 1'b1;
    if (downEvt) begin
      statN[STAT_LINK_BIT] = 1'b0;
      statN[STAT_ANDONE_BIT] = 1'b0;
    end
  end

  always_comb begin
    sstatN = sstatQ;
    if (stb.softRst) sstatN = sstatN & SSTAT_KEEP;
    if (upEvt) sstatN = (sstatN & ~SSTAT_LINKM) | SSTAT_UP;
    if (downEvt) sstatN = sstatN & ~SSTAT_LINKM;
  end

  always_comb begin
    unique case (stb.rdSrc)
      SRC_CTRL:    rdMux = ctrlQ;
      SRC_STAT:    rdMux = statQ;
      SRC_ID:      rdMux = VAL_ID;
      SRC_EXTID:   rdMux = EXT_ID;
      SRC_ADV:     rdMux = advQ;
      SRC_PARTNER: rdMux = VAL_PARTNER;
      SRC_GCTRL:   rdMux = VAL_GCTRL;
      SRC_GSTAT:   rdMux = VAL_GSTAT;
      SRC_SCTRL:   rdMux = sctrlQ;
      SRC_SSTAT:   rdMux = sstatQ;
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= RST_CTRL;
      statQ <= RST_STAT;
      advQ <= RST_ADV;
      sctrlQ <= RST_SCTRL;
      sstatQ <= '0;
      linkSeenQ <= 1'b0;
      rdData <= '0;
      linkResetPulse <= 1'b0;
    end else begin
      if (stb.softRst) ctrlQ <= ctrlQ & CTRL_KEEP;
      else if (stb.wrCtrl) ctrlQ <= wrData;
      if (stb.wrAdv) advQ <= wrData;
      if (stb.wrSpecCtrl) sctrlQ <= wrData;
      statQ <= statN;
      sstatQ <= sstatN;
      linkSeenQ <= linkUp;
      if (stb.rdAny) rdData <= rdMux;
      linkResetPulse <= stb.softRst;
    end
  end

  // R5: the reset-request bit is never held in control
  a_r5_ctrl_top_clear: assert property (@(posedge clk) disable iff (!rstN) !ctrlQ[SOFT_RST_BIT]);
  // R8: link-up event sets live link fields and negotiation-complete
  a_r8_link_up: assert property (@(posedge clk) disable iff (!rstN)
    upEvt |=> (statQ[STAT_ANDONE_BIT] && sstatQ[15:13] == 3'b101 && sstatQ[11:10] == 2'b11));
  // R9: link-down event clears live and latched link bits
  a_r9_link_down: assert property (@(posedge clk) disable iff (!rstN)
    downEvt |=> (!statQ[STAT_LINK_BIT] && !statQ[STAT_ANDONE_BIT] && !sstatQ[SSTAT_LIVE_BIT]));
  // R10: latched bit rises only after a status read that saw a live link
  a_r10_latch_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statQ[STAT_LINK_BIT]) |-> ($past(stb.rdStatus) && $past(sstatQ[SSTAT_LIVE_BIT])));
endmodule

// File: rtl/mgmtRegBank.sv
module mgmtRegBank
  import mgmtRegPkg::*;
#(
  parameter logic [DATA_W-1:0] EXT_ID = 16'h0C54
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              linkUp,
  output logic              linkResetPulse
);
  ctrlStbT stb;

  mgmtRegCtrl u_ctrl (
    .addr  (addr),
    .wrTop (wrData[SOFT_RST_BIT]),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .stb   (stb)
  );

  mgmtRegData #(.EXT_ID(EXT_ID)) u_data (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .wrData         (wrData),
    .linkUp         (linkUp),
    .rdData         (rdData),
    .linkResetPulse (linkResetPulse)
  );

  // R7: gigabit status reads its constant
  a_r7_gstat_const: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 5'd10) |=> rdData == VAL_GSTAT);
  // R3: empty, unimplemented and write-only entries read zero
  a_r3_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (classify(addr) == ACC_NONE || classify(addr) == ACC_WO)) |=> rdData == '0);
  // R6: a link-reset pulse is always caused by a soft-reset write
  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    linkResetPulse |-> $past(wrEn && addr == 5'd0 && wrData[SOFT_RST_BIT]));
endmodule

// File: tb/mgmtRegBank_tb.sv
`timescale 1ns/1ps
module mgmtRegBank_tb;
  localparam logic [15:0] EXT_ID = 16'h0C54;
  localparam int NVEC = 28;
  // {write, addr, data-or-expected}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 5'd0,  16'h1140},  // R1
    {1'b0, 5'd1,  16'h7949},  // R1
    {1'b0, 5'd2,  16'h0141},  // R1
    {1'b0, 5'd3,  EXT_ID},    // R1
    {1'b0, 5'd4,  16'h01E1},  // R1
    {1'b0, 5'd5,  16'h01E0},  // R1
    {1'b0, 5'd9,  16'h1E00},  // R1
    {1'b0, 5'd10, 16'h3C00},  // R7
    {1'b0, 5'd16, 16'h0068},  // R1
    {1'b0, 5'd17, 16'h0000},  // R1
    {1'b0, 5'd6,  16'h0000},  // R3
    {1'b0, 5'd7,  16'h0000},  // R3
    {1'b0, 5'd29, 16'h0000},  // R3
    {1'b0, 5'd11, 16'h0000},  // R3
    {1'b0, 5'd31, 16'h0000},  // R3
    {1'b1, 5'd2,  16'hFFFF},  // R4 read-only write
    {1'b0, 5'd2,  16'h0141},  // R4
    {1'b1, 5'd9,  16'h1234},  // R4
    {1'b0, 5'd9,  16'h1E00},  // R4
    {1'b1, 5'd29, 16'h5A5A},  // R4 write-only write
    {1'b0, 5'd29, 16'h0000},  // R3
    {1'b1, 5'd10, 16'h0000},  // R7
    {1'b0, 5'd10, 16'h3C00},  // R7
    {1'b1, 5'd16, 16'h5555},  // R4
    {1'b0, 5'd16, 16'h5555},  // R4
    {1'b1, 5'd0,  16'h0100},  // R4
    {1'b0, 5'd0,  16'h0100},  // R4
    {1'b1, 5'd4,  16'hABCD}   // R4, read back below
  };

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0, linkUp = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wrData = '0, rdData, v;
  logic linkResetPulse;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mgmtRegBank #(.EXT_ID(EXT_ID)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .linkUp(linkUp), .linkResetPulse(linkResetPulse)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdData at reset", rdData, 16'h0);
    check("R1 pulse at reset", {15'b0, linkResetPulse}, 16'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][21]) begin
        doWrite(VEC[i][20:16], VEC[i][15:0]);
        check("R6 no pulse on plain write", {15'b0, linkResetPulse}, 16'h0);
      end else begin
        doRead(VEC[i][20:16], v);
        check($sformatf("R1/R3/R4/R7 vector %0d", i), v, VEC[i][15:0]);
      end
    end

    // R2: read data holds while no strobe
    doRead(5'd4, v);
    check("R4 advertisement written", v, 16'hABCD);
    addr = 5'd2;
    repeat (3) @(negedge clk);
    check("R2 hold without strobe", rdData, 16'hABCD);

    // R8 / R10: link comes up
    @(negedge clk); linkUp = 1'b1;
    doRead(5'd17, v);
    check("R8 specific status after up", v, 16'hAC00);
    doRead(5'd1, v);
    check("R8 status bit5 set, bit2 not yet", v, 16'h7969);
    doRead(5'd1, v);
    check("R10 second status read shows link", v, 16'h796D);

    // R9: link goes down
    @(negedge clk); linkUp = 1'b0;
    doRead(5'd17, v);
    check("R9 specific status after down", v, 16'h0000);
    doRead(5'd1, v);
    check("R9 status after down", v, 16'h7949);

    // R10: short drop still visible
    @(negedge clk); linkUp = 1'b1;
    doRead(5'd1, v); doRead(5'd1, v);
    check("R10 latched after reup", v, 16'h796D);
    @(negedge clk); linkUp = 1'b0;
    @(negedge clk); linkUp = 1'b1;
    doRead(5'd1, v);
    check("R10 drop seen on read", v, 16'h7969);
    doRead(5'd1, v);
    check("R10 link back on next read", v, 16'h796D);

    // R11: link change on the same edge as a status read
    @(negedge clk); linkUp = 1'b0; addr = 5'd1; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
    check("R11 read returns pre-update", rdData, 16'h796D);
    doRead(5'd1, v);
    check("R11 update applied after", v, 16'h7949);

    // R5 / R6: soft reset
    doWrite(5'd0, 16'h3FFF);
    check("R6 no pulse on control write", {15'b0, linkResetPulse}, 16'h0);
    @(negedge clk); linkUp = 1'b1;
    doRead(5'd17, v);
    check("R8 up before soft reset", v, 16'hAC00);
    doWrite(5'd0, 16'h8000);
    check("R6 pulse after soft reset", {15'b0, linkResetPulse}, 16'h1);
    @(negedge clk);
    check("R6 pulse one cycle", {15'b0, linkResetPulse}, 16'h0);
    doRead(5'd0, v);
    check("R5 control masked", v, 16'h3140);
    doRead(5'd1, v);
    check("R5 status reloaded", v, 16'h7949);
    doRead(5'd17, v);
    check("R5 specific status masked", v, 16'hA000);
    doRead(5'd1, v);
    check("R5 status stays after read", v, 16'h7949);
    doRead(5'd4, v);
    check("R5 advertisement untouched", v, 16'hABCD);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule